// File: doc/BRIEF.md
# Transmit Serial Audio Frame Generator

This block turns pairs of parallel PCM samples into a three-wire serial audio stream. It runs directly on the audio master clock. From that clock it divides down a bit clock and a left/right word-select, and it places each channel's sample inside its half-frame according to a chosen alignment, bit order and sample width. A producer offers a left/right pair with a valid/ready handshake. The pair is taken once per frame. If no pair is offered, the last pair is sent again and an underrun indication is raised.

Every setting is sampled at the same instant as the samples, which is the final master-clock cycle of a frame. The frame that is currently being shifted therefore never sees a setting change part way through. Two strobes mark the frame edges so that nearby logic can stay aligned with the stream.

Top module: `aud_ser_tx`

## Requirements
- R1: The bit clock divides the master clock by 4 when `cfg_mclk_384`=0 (256fs), by 6 when `cfg_mclk_384`=1 and `cfg_bclk_48`=0, and by 8 when both are 1. Within each bit slot, `bclk` is low for the first half of the divide and high for the second half. A frame holds 48 slots for 384fs/48fs and 64 slots otherwise, so a 48fs request at 256fs runs at 64fs.
- R2: `ws` is low for the first half of the frame (left channel) and high for the second half (right channel). It changes only on a falling edge of `bclk`.
- R3: `cfg_len` selects the sample width: 0 gives 16 bits, 1 gives 18, 2 gives 20 and 3 gives 24. The sample is bits [width-1:0] of the input word, and the bits above it are ignored.
- R4: `cfg_lsb_first`=0 sends the sample MSB first. `cfg_lsb_first`=1 sends it LSB first.
- R5: `cfg_fmt`=0 (and the spare code 3) is left-aligned: the first sample bit occupies slot 0 of the half-frame.
- R6: `cfg_fmt`=2 is the I2S-style alignment: the first sample bit occupies slot 1 of the half-frame. Bits that would fall beyond the half-frame are not sent, so 24-bit samples in 24-slot halves lose their last bit.
- R7: `cfg_fmt`=1 is right-aligned: the last sample bit occupies the final slot of the half-frame.
- R8: Every slot that does not carry a sample bit drives `sdata` low.
- R9: `smp_ready` is high only in the final master-clock cycle of a frame, and in the first cycle after reset is released. Configuration and samples are captured only in that cycle. Changing the configuration in any other cycle has no effect on the frame being sent.
- R10: When `smp_valid` is low in the capture cycle, the previous pair is sent again and `underrun` is high for that whole frame. The next frame that captures a valid pair clears it.
- R11: `frame_start` is high for the first master-clock cycle of each frame. `frame_end` is high for the final master-clock cycle of the last right-channel slot.
- R12: While `rst_n` is low, all outputs are low. After release, the first frame starts one cycle later with zeroed samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mclk_384 | input | 1 | Master clock ratio: 0 = 256fs, 1 = 384fs |
| cfg_bclk_48 | input | 1 | Bit clock ratio: 0 = 64fs, 1 = 48fs |
| cfg_len | input | 2 | Sample width code |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_fmt | input | 2 | Alignment: 0 left, 1 right, 2 I2S, 3 left |
| smp_left | input | 24 | Left sample, right-aligned in the word |
| smp_right | input | 24 | Right sample, right-aligned in the word |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Sample pair and configuration captured this cycle |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select, high for the right channel |
| sdata | output | 1 | Serial data |
| frame_start | output | 1 | First cycle of a frame |
| frame_end | output | 1 | Last cycle of a frame |
| underrun | output | 1 | Current frame repeats the previous pair |

## Verification
The bench builds the block with its default ratios: 256 and 384 for the master clock, 48 and 64 for the bit clock, and a 24-bit sample word. These defaults make all three divide factors (4, 6 and 8) and both half-frame widths (24 and 32 slots) reachable. The widest sample can therefore meet the narrowest half-frame, which exercises the right-aligned case with no leading padding and the I2S case that drops a bit. The fallback of 256fs with a 48fs request is also reachable under these defaults.

// File: rtl/aud_ser_pkg.sv
// Shared types for the serial audio transmitter.
// Assumes sample widths are one of four fixed codes.
package aud_ser_pkg;

    typedef enum logic [1:0] {
        FMT_LEFT     = 2'd0,
        FMT_RIGHT    = 2'd1,
        FMT_I2S      = 2'd2,
        FMT_LEFT_ALT = 2'd3
    } fmt_e;

    typedef struct packed {
        logic       mclk_384;
        logic       bclk_48;
        logic [1:0] len_code;
        logic       lsb_first;
        fmt_e       fmt;
    } cfg_t;

    // Sample width in bits for a width code.
    function automatic int len_bits(input logic [1:0] code);
        case (code)
            2'd0:    return 16;
            2'd1:    return 18;
            2'd2:    return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_ser_clkgen.sv
// Bit clock divider: counts master-clock cycles inside one bit slot.
// Assumes div is even and only changes together with a restart pulse.
module aud_ser_clkgen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic [DIV_W-1:0] phase,
    output logic             bclk,
    output logic             tick
);

    // Phase counter: wraps at div-1, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (phase == div - DIV_W'(1))
            phase <= '0;
        else
            phase <= phase + DIV_W'(1);
    end

    // Low half then high half of each slot; tick marks the slot's last cycle.
    assign bclk = run && (phase >= (div >> 1));
    assign tick = run && (phase == div - DIV_W'(1));

    // R1
    div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase < div));

endmodule

// File: rtl/aud_ser_frame.sv
// Frame sequencer: counts bit slots, produces word select and the capture point.
// Assumes half_slots changes only in the capture cycle.
module aud_ser_frame #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [SLOT_W-1:0] half_slots,
    output logic              run,
    output logic              load,
    output logic [SLOT_W-1:0] slot,
    output logic              ws,
    output logic              frame_end
);

    logic [SLOT_W:0] frame_last;
    logic            at_last;

    assign frame_last = {half_slots, 1'b0} - (SLOT_W+1)'(1);
    assign at_last    = ({1'b0, slot} == frame_last);
    assign load       = !run || (tick && at_last);
    assign frame_end  = run && tick && at_last;
    assign ws         = run && (slot >= half_slots);

    // Run flag: low only in the cycle after reset so the first frame captures.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 1'b0;
        else        run <= 1'b1;
    end

    // Slot counter: restarts on capture, advances on each slot tick.
    always_ff @(posedge clk) begin
        if (!rst_n || load) slot <= '0;
        else if (tick)      slot <= slot + SLOT_W'(1);
    end

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, slot} <= frame_last));

endmodule

// File: rtl/aud_ser_bitsel.sv
// Data bit picker: maps the current slot to a sample bit or to zero.
// Assumes half_slots is at least the selected sample width.
module aud_ser_bitsel
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 6
) (
    input  logic [SAMPLE_W-1:0] left,
    input  logic [SAMPLE_W-1:0] right,
    input  logic [SLOT_W-1:0]   slot,
    input  logic [SLOT_W-1:0]   half_slots,
    input  logic                ws,
    input  logic [1:0]          len_code,
    input  logic                lsb_first,
    input  fmt_e                fmt,
    output logic                bit_out
);

    int                  pos, first, len, idx, sel;
    logic [SAMPLE_W-1:0] word;

    // Position inside the half-frame, alignment offset, then bit index.
    always_comb begin
        pos  = int'(slot) - (ws ? int'(half_slots) : 0);
        word = ws ? right : left;
        len  = len_bits(len_code);
        case (fmt)
            FMT_RIGHT: first = int'(half_slots) - len;
            FMT_I2S:   first = 1;
            default:   first = 0;
        endcase
        idx     = pos - first;
        sel     = lsb_first ? idx : (len - 1 - idx);
        bit_out = 1'b0;
        if (idx >= 0 && idx < len) begin
            for (int b = 0; b < SAMPLE_W; b++) begin
                if (b == sel) bit_out = word[b];
            end
        end
    end

endmodule

// File: rtl/aud_ser_tx.sv
// Serial audio transmitter top: holds the captured configuration and samples,
// derives the divide factor and half-frame width, and drives the stream.
// Assumes clk is the audio master clock at 256fs or 384fs.
module aud_ser_tx
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int MCLK_LO  = 256,
    parameter int MCLK_HI  = 384,
    parameter int BCLK_LO  = 48,
    parameter int BCLK_HI  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_mclk_384,
    input  logic                cfg_bclk_48,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_lsb_first,
    input  logic [1:0]          cfg_fmt,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_valid,
    output logic                smp_ready,
    output logic                bclk,
    output logic                ws,
    output logic                sdata,
    output logic                frame_start,
    output logic                frame_end,
    output logic                underrun
);

    localparam int DIV_W  = $clog2(MCLK_HI / BCLK_LO) + 1;
    localparam int SLOT_W = $clog2(BCLK_HI / 2) + 1;
    localparam logic [DIV_W-1:0]  DIV_LO_MCLK = DIV_W'(MCLK_LO / BCLK_HI);
    localparam logic [DIV_W-1:0]  DIV_HI_FAST = DIV_W'(MCLK_HI / BCLK_HI);
    localparam logic [DIV_W-1:0]  DIV_HI_SLOW = DIV_W'(MCLK_HI / BCLK_LO);
    localparam logic [SLOT_W-1:0] HALF_NARROW = SLOT_W'(BCLK_LO / 2);
    localparam logic [SLOT_W-1:0] HALF_WIDE   = SLOT_W'(BCLK_HI / 2);

    cfg_t                cfg_in, cfg_q;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic                underrun_q;
    logic [DIV_W-1:0]    div, phase;
    logic [SLOT_W-1:0]   half_slots, slot;
    logic                run, load, tick, ws_i, bit_i;

    // Gather configuration pins into one record.
    always_comb begin
        cfg_in.mclk_384  = cfg_mclk_384;
        cfg_in.bclk_48   = cfg_bclk_48;
        cfg_in.len_code  = cfg_len;
        cfg_in.lsb_first = cfg_lsb_first;
        cfg_in.fmt       = fmt_e'(cfg_fmt);
    end

    // Divide factor and half-frame width from the captured ratios.
    always_comb begin
        if (!cfg_q.mclk_384)    div = DIV_LO_MCLK;
        else if (cfg_q.bclk_48) div = DIV_HI_SLOW;
        else                    div = DIV_HI_FAST;
        half_slots = (cfg_q.mclk_384 && cfg_q.bclk_48) ? HALF_NARROW : HALF_WIDE;
    end

    // Capture configuration and samples once per frame; flag a missing pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            left_q     <= '0;
            right_q    <= '0;
            underrun_q <= 1'b0;
        end else if (load) begin
            cfg_q <= cfg_in;
            if (smp_valid) begin
                left_q     <= smp_left;
                right_q    <= smp_right;
                underrun_q <= 1'b0;
            end else begin
                underrun_q <= 1'b1;
            end
        end
    end

    aud_ser_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(load), .div(div),
        .phase(phase), .bclk(bclk), .tick(tick)
    );

    aud_ser_frame #(.SLOT_W(SLOT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick), .half_slots(half_slots),
        .run(run), .load(load), .slot(slot), .ws(ws_i), .frame_end(frame_end)
    );

    aud_ser_bitsel #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_bitsel (
        .left(left_q), .right(right_q), .slot(slot), .half_slots(half_slots),
        .ws(ws_i), .len_code(cfg_q.len_code), .lsb_first(cfg_q.lsb_first),
        .fmt(cfg_q.fmt), .bit_out(bit_i)
    );

    assign ws          = ws_i;
    assign sdata       = run && bit_i;
    assign frame_start = run && (phase == '0) && (slot == '0);
    assign smp_ready   = rst_n && load;
    assign underrun    = underrun_q;

    // R2
    ws_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ws != $past(ws)) |-> ($past(bclk) && !bclk));

    // R5
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bclk && $past(bclk)) |-> $stable(sdata));

    // R9
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready);

    // R10
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && !smp_valid) |=> underrun);

    // R10
    underrun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_ready && smp_valid) |=> !underrun);

    // R11
    end_then_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> frame_start);

    // R11
    start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (!bclk && !ws));

endmodule

// File: tb/aud_ser_tx_bench.sv
// Bench: a configuration/sample table walked one frame per entry, then
// directed tests for reset, underrun and mid-run reset.
module aud_ser_tx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mclk_384 = 1'b0, cfg_bclk_48 = 1'b0, cfg_lsb_first = 1'b0;
    logic [1:0]  cfg_len = 2'd0, cfg_fmt = 2'd0;
    logic [23:0] smp_left = '0, smp_right = '0;
    logic        smp_valid = 1'b0;
    logic        smp_ready, bclk, ws, sdata, frame_start, frame_end, underrun;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    aud_ser_tx u_aud_ser_tx (
        .clk(clk), .rst_n(rst_n), .cfg_mclk_384(cfg_mclk_384),
        .cfg_bclk_48(cfg_bclk_48), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .cfg_fmt(cfg_fmt), .smp_left(smp_left), .smp_right(smp_right),
        .smp_valid(smp_valid), .smp_ready(smp_ready), .bclk(bclk), .ws(ws),
        .sdata(sdata), .frame_start(frame_start), .frame_end(frame_end),
        .underrun(underrun)
    );

    // {m384, b48, len[1:0], lsb, fmt[1:0], left[23:0], right[23:0]}
    localparam logic [54:0] VEC [8] = '{
        {1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 24'hFFA5C3, 24'h003C5A},
        {1'b0, 1'b0, 2'd3, 1'b1, 2'd2, 24'hC0FFEE, 24'h123456},
        {1'b1, 1'b0, 2'd1, 1'b0, 2'd1, 24'hF2ABCD, 24'h013579},
        {1'b1, 1'b1, 2'd2, 1'b0, 2'd0, 24'h0F1E2D, 24'hEA5A5A},
        {1'b1, 1'b1, 2'd3, 1'b0, 2'd2, 24'h800001, 24'hFEDCBA},
        {1'b0, 1'b1, 2'd2, 1'b1, 2'd1, 24'h0BEEF1, 24'h04C0DE},
        {1'b1, 1'b0, 2'd0, 1'b1, 2'd3, 24'h77F00F, 24'h001234},
        {1'b1, 1'b1, 2'd3, 1'b1, 2'd1, 24'hABCDEF, 24'h5A5A5A}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_div(input logic [54:0] v);
        return !v[54] ? 4 : (v[53] ? 8 : 6);
    endfunction

    function automatic int ref_half(input logic [54:0] v);
        return (v[54] && v[53]) ? 24 : 32;
    endfunction

    // Expected serial bit for a slot, built from R3..R8.
    function automatic logic ref_bit(input logic [54:0] v, input int s);
        int half, len, p, idx;
        logic [23:0] w;
        half = ref_half(v);
        len  = (v[52:51] == 2'd0) ? 16 : (v[52:51] == 2'd1) ? 18 :
               (v[52:51] == 2'd2) ? 20 : 24;
        w    = (s >= half) ? v[23:0] : v[47:24];
        p    = (s >= half) ? s - half : s;
        case (v[49:48])
            2'd1:    idx = p - (half - len);
            2'd2:    idx = p - 1;
            default: idx = p;
        endcase
        if (idx < 0 || idx >= len) return 1'b0;
        return v[50] ? w[idx] : w[len - 1 - idx];
    endfunction

    // Walk one frame from its first cycle; optionally disturb config mid-frame.
    task automatic walk(input logic [54:0] v, input bit scr, input string tag);
        int d, h, e_clk, e_ws, e_dat, e_end, e_rdy, bad_s, bad_a, bad_e;
        bit fe;
        d = ref_div(v); h = ref_half(v);
        e_clk = 0; e_ws = 0; e_dat = 0; e_end = 0; e_rdy = 0;
        bad_s = -1; bad_a = 0; bad_e = 0;
        check(frame_start === 1'b1, {"R11 frame_start ", tag}, frame_start, 1);
        for (int s = 0; s < 2 * h; s++) begin
            for (int c = 0; c < d; c++) begin
                if (bclk !== (c >= d / 2)) e_clk++;
                if (c == 0) begin
                    if (ws !== (s >= h)) e_ws++;
                    if (sdata !== ref_bit(v, s)) begin
                        e_dat++;
                        if (bad_s < 0) begin bad_s = s; bad_a = sdata; bad_e = ref_bit(v, s); end
                    end
                end
                fe = (s == 2 * h - 1) && (c == d - 1);
                if (frame_end !== fe) e_end++;
                if (smp_ready !== fe) e_rdy++;
                if (scr && s == 5 && c == 0) begin
                    cfg_lsb_first = ~cfg_lsb_first;
                    cfg_fmt       = cfg_fmt + 2'd1;
                    cfg_len       = cfg_len + 2'd1;
                    cfg_bclk_48   = ~cfg_bclk_48;
                end
                @(negedge clk);
            end
        end
        check(e_clk == 0, {"R1 bclk shape ", tag}, e_clk, 0);
        check(e_ws == 0, {"R2 ws halves ", tag}, e_ws, 0);
        check(e_dat == 0, $sformatf("R3 R4 R5 R6 R7 R8 R9 data %s slot %0d", tag, bad_s), bad_a, bad_e);
        check(e_end == 0, {"R11 frame_end ", tag}, e_end, 0);
        check(e_rdy == 0, {"R9 ready timing ", tag}, e_rdy, 0);
    endtask

    task automatic offer(input logic [54:0] v);
        cfg_mclk_384 = v[54]; cfg_bclk_48 = v[53]; cfg_len = v[52:51];
        cfg_lsb_first = v[50]; cfg_fmt = v[49:48];
        smp_left = v[47:24]; smp_right = v[23:0]; smp_valid = 1'b1;
        while (smp_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_left = 24'h5F5F5F; smp_right = 24'hA0A0A0;
    endtask

    task automatic check_reset_outputs(input string tag);
        check({bclk, ws, sdata, frame_start, frame_end, smp_ready, underrun} == 7'b0,
              {"R12 outputs low ", tag},
              {bclk, ws, sdata, frame_start, frame_end, smp_ready, underrun}, 0);
    endtask

    initial begin
        logic [54:0] zv;
        // Reset state
        cfg_mclk_384 = VEC[0][54]; cfg_bclk_48 = VEC[0][53]; cfg_len = VEC[0][52:51];
        cfg_lsb_first = VEC[0][50]; cfg_fmt = VEC[0][49:48];
        repeat (4) @(negedge clk);
        check_reset_outputs("power-up");
        rst_n = 1'b1; #1;
        check(smp_ready === 1'b1, "R12 R9 capture after release", smp_ready, 1);
        @(negedge clk);
        check(underrun === 1'b1, "R12 R10 first frame underrun", underrun, 1);
        zv = {VEC[0][54:48], 48'h0};
        walk(zv, 1'b0, "after reset");

        // Table of configurations and samples
        for (int i = 0; i < 8; i++) begin
            offer(VEC[i]);
            check(underrun === 1'b0, $sformatf("R10 underrun clear vec %0d", i), underrun, 0);
            walk(VEC[i], 1'b1, $sformatf("vec %0d", i));
        end

        // Underrun: pair repeated, flag held for the frame, cleared by next pair
        offer(VEC[2]);
        walk(VEC[2], 1'b0, "before underrun");
        check(underrun === 1'b1, "R10 underrun set", underrun, 1);
        walk(VEC[2], 1'b0, "repeated pair");
        offer(VEC[4]);
        check(underrun === 1'b0, "R10 underrun cleared", underrun, 0);

        // Mid-frame reset
        repeat (37) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_outputs("mid-frame");
        rst_n = 1'b1; #1;
        check(smp_ready === 1'b1, "R12 capture after second release", smp_ready, 1);
        @(negedge clk);
        walk({VEC[4][54:48], 48'h0}, 1'b0, "after mid reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL R12 watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule